// File: doc/BRIEF.md
# Address-Latched Byte-Lane Static Memory

This block is a clocked, synthesizable model of a 16-bit static memory. The address and chip select it uses are buffered by a latch that is controlled by an active-low latch enable. While the latch enable is high the latch is transparent and the external address and select reach the array directly. While it is low, the array keeps using the values captured at the last clock edge on which the enable was high. The host can therefore free its address bus in the middle of an access while write enable, output enable and the byte enables still act at once.

Each 8-bit lane has its own active-low enable. Lane 0 is bits 7:0 and is enabled by the lower enable. Lane 1 is bits 15:8 and is enabled by the upper enable. Writes are masked per lane. Reads return each lane together with one data-bus drive bit per lane. Every input is sampled on the rising clock edge. Read data and drive bits are registered, so they appear one cycle after the edge that sampled the request. The array holds `DEPTH` words. The address port is `ADDR_W` bits wide, and the address bits above log2(`DEPTH`) are not decoded.

Top module: `latched_lane_sram`

## Requirements
- R1: While `ale_n_i` is 1 at a clock edge, the access at that edge uses the current `addr_i` and `cs_n_i`.
- R2: While `ale_n_i` is 0, the access uses the address and select captured at the most recent edge on which `ale_n_i` was 1. Changes on `addr_i` and `cs_n_i` have no effect during that time.
- R3: While the latch holds, `we_n_i`, `oe_n_i`, `ub_n_i` and `lb_n_i` still take effect at every edge.
- R4: An edge with effective select 0 and `we_n_i` 0 writes `wdata_i[7:0]` if `lb_n_i` is 0 and writes `wdata_i[15:8]` if `ub_n_i` is 0. The two lanes are independent, and with both enables at 1 nothing is stored.
- R5: After a write edge `dq_oe_o` is 2'b00, even if `oe_n_i` was 0.
- R6: After an edge with effective select 0, `we_n_i` 1 and `oe_n_i` 0, `dq_oe_o[0]` is 1 exactly when `lb_n_i` was 0, and `dq_oe_o[1]` is 1 exactly when `ub_n_i` was 0. Each driven lane of `rdata_o` holds the stored byte.
- R7: After an edge with effective select 1 (standby), `dq_oe_o` is 2'b00.
- R8: After a read edge with `oe_n_i` 1, `dq_oe_o` is 2'b00.
- R9: A lane of `rdata_o` whose `dq_oe_o` bit is 0 reads as all zeros.
- R10: During reset and after it, `dq_oe_o` is 2'b00 and `rdata_o` is 0. The held select is 1 (deselected), so with the latch closed after reset no write takes place.
- R11: Address bits at and above log2(`DEPTH`) are ignored, so `addr_i` and `addr_i + DEPTH` select the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | External word address |
| cs_n_i | input | 1 | External chip select, active low |
| ale_n_i | input | 1 | Latch enable: 1 transparent, 0 hold |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| ub_n_i | input | 1 | Upper lane (15:8) enable, active low |
| lb_n_i | input | 1 | Lower lane (7:0) enable, active low |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data, zero on undriven lanes |
| dq_oe_o | output | 2 | Per-lane data-bus drive enable, bit 0 lower |

## Verification
The latch hold and a write can fall in the same cycle. The bench provokes this by capturing address 5 with the latch open. It then closes the latch and, on that same edge, presents address 9 with a write strobe and both lanes enabled. Reading address 5 afterwards must return the new word. A second case captures a deselect and then closes the latch while presenting an active select and a write. The word read back must be unchanged, which shows that a held deselect takes precedence over a live write strobe.

// File: rtl/lsram_pkg.sv
package lsram_pkg;
   localparam int unsigned LANES    = 2;
   localparam int unsigned LANE_W   = 8;
   localparam int unsigned WORD_W   = LANES * LANE_W;
   localparam int unsigned ADDR_W_D = 18;
   localparam int unsigned DEPTH_D  = 1024;

   typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/lsram_addr_latch.sv
module lsram_addr_latch #(
   parameter int unsigned ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ale_n,
   input  logic [ADDR_W-1:0] addr_ext,
   input  logic              cs_n_ext,
   output logic [ADDR_W-1:0] addr_eff,
   output logic              cs_eff_n
);
   logic [ADDR_W-1:0] held_addr;
   logic              held_cs_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_addr <= '0;
         held_cs_n <= 1'b1;
      end else if (ale_n) begin
         held_addr <= addr_ext;
         held_cs_n <= cs_n_ext;
      end
   end

   // open latch: external lines pass; closed: captured copy is used
   assign addr_eff = ale_n ? addr_ext : held_addr;
   assign cs_eff_n = ale_n ? cs_n_ext : held_cs_n;
endmodule

// File: rtl/lsram_lane_bank.sv
module lsram_lane_bank #(
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [LANE_W-1:0] wbyte,
   output logic [LANE_W-1:0] rbyte
);
   logic [LANE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[idx] <= wbyte;
   end

   assign rbyte = cells[idx];
endmodule

// File: rtl/lsram_lane_out.sv
module lsram_lane_out #(
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drive,
   input  logic [LANE_W-1:0] rbyte,
   output logic [LANE_W-1:0] dout,
   output logic              dout_en
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout    <= '0;
         dout_en <= 1'b0;
      end else begin
         dout_en <= drive;
         dout    <= drive ? rbyte : '0;
      end
   end
endmodule

// File: rtl/latched_lane_sram.sv
module latched_lane_sram
   import lsram_pkg::*;
#(
   parameter int unsigned ADDR_W = ADDR_W_D,
   parameter int unsigned DEPTH  = DEPTH_D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              cs_n_i,
   input  logic              ale_n_i,
   input  logic              we_n_i,
   input  logic              oe_n_i,
   input  logic              ub_n_i,
   input  logic              lb_n_i,
   input  logic [15:0]       wdata_i,
   output logic [15:0]       rdata_o,
   output logic [1:0]        dq_oe_o
);
   localparam int unsigned IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("DEPTH exceeds the range of ADDR_W");
   end
   if (WORD_W != 16) begin : g_bad_word
      $error("two byte lanes of 8 bits are required");
   end

   logic [ADDR_W-1:0] addr_eff;
   logic              cs_eff_n;
   logic              acc_wr;
   logic              acc_rd;
   lane_mask_t        lane_n;
   logic [IDX_W-1:0]  idx;

   lsram_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ale_n    (ale_n_i),
      .addr_ext (addr_i),
      .cs_n_ext (cs_n_i),
      .addr_eff (addr_eff),
      .cs_eff_n (cs_eff_n)
   );

   assign lane_n = {ub_n_i, lb_n_i};
   assign acc_wr = !cs_eff_n && !we_n_i;
   assign acc_rd = !cs_eff_n &&  we_n_i && !oe_n_i;
   assign idx    = addr_eff[IDX_W-1:0];

   if (IDX_W < ADDR_W) begin : g_alias
      logic unused_hi_bits;
      assign unused_hi_bits = ^addr_eff[ADDR_W-1:IDX_W];
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] rbyte;

      lsram_lane_bank #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_bank (
         .clk   (clk),
         .wr_en (acc_wr && !lane_n[l]),
         .idx   (idx),
         .wbyte (wdata_i[l*LANE_W +: LANE_W]),
         .rbyte (rbyte)
      );

      lsram_lane_out #(.LANE_W(LANE_W)) u_out (
         .clk     (clk),
         .rst_n   (rst_n),
         .drive   (acc_rd && !lane_n[l]),
         .rbyte   (rbyte),
         .dout    (rdata_o[l*LANE_W +: LANE_W]),
         .dout_en (dq_oe_o[l])
      );
   end
endmodule

// File: rtl/lsram_checker.sv
module lsram_checker #(
   parameter int unsigned ADDR_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ale_n_i,
   input logic              we_n_i,
   input logic              oe_n_i,
   input logic              ub_n_i,
   input logic              lb_n_i,
   input logic [ADDR_W-1:0] addr_eff,
   input logic              cs_eff_n,
   input logic [15:0]       rdata_o,
   input logic [1:0]        dq_oe_o
);
   // R2: a closed latch keeps the effective address and select steady
   p_hold_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ale_n_i && $past(!ale_n_i)) |-> ($stable(addr_eff) && $stable(cs_eff_n)));

   p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cs_eff_n && !we_n_i) |-> (dq_oe_o == 2'b00));

   p_read_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cs_eff_n && we_n_i && !oe_n_i) |-> (dq_oe_o == ~$past({ub_n_i, lb_n_i})));

   p_standby_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_eff_n) |-> (dq_oe_o == 2'b00));

   p_oe_off_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(oe_n_i) |-> (dq_oe_o == 2'b00));

   p_lo_lane_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe_o[0] |-> (rdata_o[7:0] == 8'h00));

   p_hi_lane_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe_o[1] |-> (rdata_o[15:8] == 8'h00));

   p_reset_idle_r10: assert property (@(posedge clk)
      $past(!rst_n) |-> (dq_oe_o == 2'b00 && rdata_o == 16'h0000));
endmodule

bind latched_lane_sram lsram_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ale_n_i  (ale_n_i),
   .we_n_i   (we_n_i),
   .oe_n_i   (oe_n_i),
   .ub_n_i   (ub_n_i),
   .lb_n_i   (lb_n_i),
   .addr_eff (addr_eff),
   .cs_eff_n (cs_eff_n),
   .rdata_o  (rdata_o),
   .dq_oe_o  (dq_oe_o)
);

// File: tb/latched_lane_sram_test.sv
module latched_lane_sram_test;
   localparam int CLK_P = 10;
   localparam int AW    = 18;
   localparam int DEP   = 1024;

   typedef struct packed {
      logic          ale, cs, we, oe, ub, lb;
      logic [AW-1:0] addr;
      logic [15:0]   wd;
      logic [1:0]    xoe;
      logic [15:0]   xd;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{1,0,0,1,0,0, 18'd5,    16'hA1B2, 2'b00, 16'h0000}, // R4 full write
      '{1,0,1,0,0,0, 18'd5,    16'h0000, 2'b11, 16'hA1B2}, // R6 R1 read
      '{1,0,0,1,0,0, 18'd6,    16'h5566, 2'b00, 16'h0000}, // R4
      '{1,0,0,1,1,0, 18'd6,    16'h3344, 2'b00, 16'h0000}, // R4 low lane only
      '{1,0,0,1,0,1, 18'd6,    16'h7788, 2'b00, 16'h0000}, // R4 high lane only
      '{1,0,1,0,0,0, 18'd6,    16'h0000, 2'b11, 16'h7744}, // R4 lanes independent
      '{1,0,0,1,1,1, 18'd6,    16'hFFFF, 2'b00, 16'h0000}, // R4 no lane
      '{1,0,1,0,0,0, 18'd6,    16'h0000, 2'b11, 16'h7744}, // R4 unchanged
      '{1,0,1,0,1,0, 18'd5,    16'h0000, 2'b01, 16'h00B2}, // R6 R9 low lane
      '{1,0,1,0,0,1, 18'd5,    16'h0000, 2'b10, 16'hA100}, // R6 R9 high lane
      '{1,0,1,1,0,0, 18'd5,    16'h0000, 2'b00, 16'h0000}, // R8
      '{1,1,1,0,0,0, 18'd5,    16'h0000, 2'b00, 16'h0000}, // R7
      '{1,0,0,0,0,0, 18'd7,    16'h1234, 2'b00, 16'h0000}, // R5 write with oe low
      '{1,0,1,0,0,0, 18'd7,    16'h0000, 2'b11, 16'h1234}, // R5 data landed
      '{1,0,1,0,0,0, 18'd1031, 16'h0000, 2'b11, 16'h1234}, // R11 alias
      '{1,0,1,1,0,0, 18'd5,    16'h0000, 2'b00, 16'h0000}, // R1 capture 5
      '{0,1,1,0,0,0, 18'd7,    16'h0000, 2'b11, 16'hA1B2}, // R2 R3 held read
      '{0,1,0,1,0,0, 18'd9,    16'hCAFE, 2'b00, 16'h0000}, // R2 R3 held write
      '{1,0,1,0,0,0, 18'd5,    16'h0000, 2'b11, 16'hCAFE}, // R1 R2 readback
      '{1,1,1,1,0,0, 18'd5,    16'h0000, 2'b00, 16'h0000}, // R2 capture deselect
      '{0,0,0,1,0,0, 18'd5,    16'h0BAD, 2'b00, 16'h0000}, // R2 held deselect
      '{1,0,1,0,0,0, 18'd5,    16'h0000, 2'b11, 16'hCAFE}  // R2 no write happened
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          cs_n_i = 1'b1, ale_n_i = 1'b1, we_n_i = 1'b1, oe_n_i = 1'b1;
   logic          ub_n_i = 1'b1, lb_n_i = 1'b1;
   logic [15:0]   wdata_i = '0;
   logic [15:0]   rdata_o;
   logic [1:0]    dq_oe_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   latched_lane_sram #(.ADDR_W(AW), .DEPTH(DEP)) uut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cs_n_i(cs_n_i),
      .ale_n_i(ale_n_i), .we_n_i(we_n_i), .oe_n_i(oe_n_i),
      .ub_n_i(ub_n_i), .lb_n_i(lb_n_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .dq_oe_o(dq_oe_o)
   );

   task automatic check(input string tag, input logic [1:0] xoe, input logic [15:0] xd);
      checks++;
      if (dq_oe_o !== xoe || rdata_o !== xd) begin
         errors++;
         $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", tag, dq_oe_o, rdata_o, xoe, xd);
      end
   endtask

   task automatic apply(input vec_t v);
      ale_n_i = v.ale; cs_n_i = v.cs; we_n_i = v.we; oe_n_i = v.oe;
      ub_n_i = v.ub; lb_n_i = v.lb; addr_i = v.addr; wdata_i = v.wd;
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R10 in reset", 2'b00, 16'h0000);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         check($sformatf("table row %0d (R1..R11 per row)", i), VEC[i].xoe, VEC[i].xd);
      end
      // R10: reset again, then write with the latch closed straight away
      rst_n = 1'b0;
      apply('{1,1,1,1,1,1, 18'd0, 16'h0000, 2'b00, 16'h0000});
      check("R10 reset mid-run", 2'b00, 16'h0000);
      rst_n = 1'b1;
      apply('{0,0,0,0,0,0, 18'd5, 16'hDEAD, 2'b00, 16'h0000});
      check("R10 held select deselected", 2'b00, 16'h0000);
      apply('{1,0,1,0,0,0, 18'd5, 16'h0000, 2'b11, 16'hCAFE});
      check("R10 word kept after reset", 2'b11, 16'hCAFE);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 5000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule